// File: doc/BRIEF.md
# Linked-List Descriptor DMA Engine

A single-channel memory-to-memory copy engine. It follows a chain of descriptors in memory. Software writes the descriptors, places the address of the first one on `head_ptr` and pulses `start`. For each node the engine reads eight 32-bit words. It checks the control word, then copies the node's bytes one word at a time from a source walker to a destination walker, and then moves on to the next node.

A node's bytes can form a single line or a two-dimensional block. In the 2D case each line has a fixed length, and the two walkers jump by their own strides between lines. Each word copy can run free or wait on one of the request lines. At the end of a node the engine can raise a one-cycle interrupt, can park itself until the next `start`, or both. A level pause input can also stop the engine between two words.

Top module: `lldma_engine`

## Requirements
- R1: A node is eight 32-bit words at node address + 0, 4, ... 28, holding: next pointer, control, byte count, source address, destination address, line length, source stride, destination stride. All eight are read from memory before any data moves.
- R2: With both addresses incrementing and line length 0, word k of the node is copied from source + 4k to destination + 4k, for k below byte count / 4. Byte counts and line lengths are multiples of 4.
- R3: Control bit 5 holds the source address fixed and bit 6 makes it increment. Bits 7 and 8 do the same for the destination. A fixed address is the same for every word of the node.
- R4: With a non-zero line length L, word k lies on line (4k / L) at byte offset (4k mod L). Its incrementing address is base + line × stride + offset, using the source stride on the source side and the destination stride on the destination side.
- R5: Control bits 4:0 set the pacing. Value 0 issues each word read as soon as possible. Values 1..31 issue a word read only in a cycle in which `req_lines[value]` is high; line 31 is the external request.
- R6: A non-zero next pointer makes the engine fetch that node after the current one. A zero next pointer returns the engine to idle once the node ends.
- R7: A head or next pointer with bits 4:0 not zero sets `err` and returns the engine to idle without fetching that node. `err` stays set until the next `start` from idle.
- R8: A source or destination addressing field equal to 00 or 11 sets `err` and returns the engine to idle without moving any data of that node.
- R9: When a node with control bit 31 set ends, `eon_irq` is high for exactly one cycle.
- R10: When a node with control bit 30 set ends, `status` shows 3 (paused) and no memory request is made. The next `start` continues with the next node.
- R11: `status` is 0 idle, 1 start accepted (exactly one cycle, the cycle after `start`), 2 running, 3 paused. After reset the status is 0 and `mem_req`, `eon_irq` and `err` are low.
- R12: `pause_req` held high is seen before the read of a word is issued. The engine then shows status 3 and writes nothing. A `start` resumes with that same word.
- R13: A memory request holds its address, direction and data until `mem_gnt`. Read data is taken on `mem_rvalid`. A byte count of 0 moves no data. The copy is correct for any grant pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start from idle, or resume from paused |
| pause_req | input | 1 | Level request to stop between words |
| head_ptr | input | AW | Address of the first node, taken with `start` in idle |
| req_lines | input | 32 | Pacing request lines; bit 31 is the external request |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid, at least one cycle after grant |
| mem_rdata | input | 32 | Read data |
| eon_irq | output | 1 | End-of-node interrupt pulse |
| err | output | 1 | Sticky chain error |
| status | output | 2 | Channel state code |

## Verification
A table of single-node transfers covers several cases. A plain linear copy pins the basic address sequence. A 2D block with unequal strides shows that line-start stepping is kept apart from word stepping. Fixed-source and fixed-destination nodes show that each side's mode is decoded separately. Stalled grants and toggling request lines, both a numbered line and the external one, show that progress follows the handshake and not a cycle count. Directed runs cover the rest: a two-node chain with one interrupting node, a park at the end of a node, a mid-node pause, a request line held low, a zero-length node, a misaligned link and a bad addressing field. Together they separate chaining, parking and error handling.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
  localparam int WORD_W     = 32;
  localparam int NODE_WORDS = 8;
  localparam int REQ_SEL_W  = 5;
  localparam int REQ_N      = 1 << REQ_SEL_W;
  localparam int ALIGN_BITS = 5;

  // word index inside a node; order is fixed by the memory layout
  localparam int W_NEXT  = 0;
  localparam int W_CTRL  = 1;
  localparam int W_COUNT = 2;
  localparam int W_SRC   = 3;
  localparam int W_DST   = 4;
  localparam int W_LLEN  = 5;
  localparam int W_SSTR  = 6;
  localparam int W_DSTR  = 7;

  // control word bit positions
  localparam int C_SRC_FIX = 5;
  localparam int C_SRC_INC = 6;
  localparam int C_DST_FIX = 7;
  localparam int C_DST_INC = 8;
  localparam int C_PARK    = 30;
  localparam int C_IRQ     = 31;

  typedef enum logic [2:0] {
    S_IDLE, S_LAUNCH, S_FETCH, S_CHECK, S_RD, S_WR, S_EON, S_HOLD
  } eng_state_e;

  localparam logic [1:0] STAT_IDLE  = 2'd0;
  localparam logic [1:0] STAT_START = 2'd1;
  localparam logic [1:0] STAT_RUN   = 2'd2;
  localparam logic [1:0] STAT_PARK  = 2'd3;
endpackage

// File: rtl/lldma_pace.sv
module lldma_pace
  import lldma_pkg::*;
(
  input  logic [REQ_SEL_W-1:0] sel,
  input  logic [REQ_N-1:0]     lines,
  output logic                 go
);
  // selector 0 = free running, otherwise the chosen line gates each word
  always_comb begin
    if (sel == '0) go = 1'b1;
    else           go = lines[sel];
  end
endmodule

// File: rtl/lldma_walk.sv
module lldma_walk #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] stride,
  input  logic          inc,
  input  logic          step,
  input  logic          line_end,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] WSTEP = AW'(4);
  logic [AW-1:0] line_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr       <= '0;
      line_start <= '0;
    end else if (load) begin
      addr       <= base;
      line_start <= base;
    end else if (step && inc) begin
      if (line_end) begin
        line_start <= line_start + stride;
        addr       <= line_start + stride;
      end else begin
        addr <= addr + WSTEP;
      end
    end
  end

  // a fixed-mode walker never moves outside a reload
  assert_fixed_addr_R3: assert property (@(posedge clk) disable iff (rst)
    (!inc && !load) |=> (addr == $past(addr)));
endmodule

// File: rtl/lldma_engine.sv
module lldma_engine
  import lldma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 pause_req,
  input  logic [AW-1:0]        head_ptr,
  input  logic [REQ_N-1:0]     req_lines,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [WORD_W-1:0]    mem_wdata,
  input  logic                 mem_gnt,
  input  logic                 mem_rvalid,
  input  logic [WORD_W-1:0]    mem_rdata,
  output logic                 eon_irq,
  output logic                 err,
  output logic [1:0]           status
);
  localparam int IDX_W = $clog2(NODE_WORDS);
  localparam logic [WORD_W-1:0] WBYTES = WORD_W'(4);

  eng_state_e          st;
  logic [WORD_W-1:0]   dw [NODE_WORDS];
  logic [IDX_W-1:0]    widx;
  logic [AW-1:0]       node_ptr;
  logic                rd_out;
  logic                resume_mid;
  logic [WORD_W-1:0]   bytes_left;
  logic [WORD_W-1:0]   line_left;
  logic [WORD_W-1:0]   ctrl;
  logic                pace_go;
  logic                word_done;
  logic                line_end;
  logic                walk_load;
  logic [AW-1:0]       walk_base   [2];
  logic [AW-1:0]       walk_stride [2];
  logic                walk_inc    [2];
  logic [AW-1:0]       walk_addr   [2];

  assign ctrl      = dw[W_CTRL];
  assign word_done = (st == S_WR) && mem_req && mem_gnt;
  assign line_end  = word_done && (dw[W_LLEN] != '0) && (line_left == WBYTES);
  assign walk_load = (st == S_CHECK);

  wire unused_ctrl_bits = ^ctrl[C_PARK-1:C_DST_INC+1];

  lldma_pace u_pace (
    .sel   (ctrl[REQ_SEL_W-1:0]),
    .lines (req_lines),
    .go    (pace_go)
  );

  assign walk_base[0]   = dw[W_SRC][AW-1:0];
  assign walk_base[1]   = dw[W_DST][AW-1:0];
  assign walk_stride[0] = dw[W_SSTR][AW-1:0];
  assign walk_stride[1] = dw[W_DSTR][AW-1:0];
  assign walk_inc[0]    = ctrl[C_SRC_INC];
  assign walk_inc[1]    = ctrl[C_DST_INC];

  for (genvar g = 0; g < 2; g++) begin : g_walk
    lldma_walk #(.AW(AW)) u_walk (
      .clk      (clk),
      .rst      (rst),
      .load     (walk_load),
      .base     (walk_base[g]),
      .stride   (walk_stride[g]),
      .inc      (walk_inc[g]),
      .step     (word_done),
      .line_end (line_end),
      .addr     (walk_addr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      eon_irq    <= 1'b0;
      err        <= 1'b0;
      widx       <= '0;
      node_ptr   <= '0;
      rd_out     <= 1'b0;
      resume_mid <= 1'b0;
      bytes_left <= '0;
      line_left  <= '0;
      for (int i = 0; i < NODE_WORDS; i++) dw[i] <= '0;
    end else begin
      eon_irq <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            st       <= S_LAUNCH;
            err      <= 1'b0;
            node_ptr <= head_ptr;
          end
        end
        S_LAUNCH: begin
          if (node_ptr[ALIGN_BITS-1:0] != '0) begin
            err <= 1'b1;
            st  <= S_IDLE;
          end else if (node_ptr == '0) begin
            st <= S_IDLE;
          end else begin
            st       <= S_FETCH;
            widx     <= '0;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= node_ptr;
          end
        end
        S_FETCH: begin
          if (mem_req && mem_gnt) mem_req <= 1'b0;
          if (mem_rvalid) begin
            dw[widx] <= mem_rdata;
            if (widx == IDX_W'(NODE_WORDS - 1)) begin
              st <= S_CHECK;
            end else begin
              widx     <= widx + 1'b1;
              mem_req  <= 1'b1;
              mem_addr <= node_ptr + AW'({widx + 1'b1, 2'b00});
            end
          end
        end
        S_CHECK: begin
          if (!(^ctrl[C_SRC_INC:C_SRC_FIX]) || !(^ctrl[C_DST_INC:C_DST_FIX])) begin
            err <= 1'b1;
            st  <= S_IDLE;
          end else begin
            bytes_left <= dw[W_COUNT];
            line_left  <= dw[W_LLEN];
            rd_out     <= 1'b0;
            st         <= (dw[W_COUNT] == '0) ? S_EON : S_RD;
          end
        end
        S_RD: begin
          if (!rd_out) begin
            if (pause_req) begin
              st         <= S_HOLD;
              resume_mid <= 1'b1;
            end else if (pace_go) begin
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= walk_addr[0];
              rd_out   <= 1'b1;
            end
          end else begin
            if (mem_req && mem_gnt) mem_req <= 1'b0;
            if (mem_rvalid) begin
              rd_out    <= 1'b0;
              st        <= S_WR;
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= walk_addr[1];
              mem_wdata <= mem_rdata;
            end
          end
        end
        S_WR: begin
          if (mem_gnt) begin
            mem_req    <= 1'b0;
            mem_we     <= 1'b0;
            bytes_left <= bytes_left - WBYTES;
            line_left  <= (line_left == WBYTES) ? dw[W_LLEN] : line_left - WBYTES;
            st         <= (bytes_left <= WBYTES) ? S_EON : S_RD;
          end
        end
        S_EON: begin
          eon_irq  <= ctrl[C_IRQ];
          node_ptr <= dw[W_NEXT][AW-1:0];
          if (dw[W_NEXT][ALIGN_BITS-1:0] != '0) begin
            err <= 1'b1;
            st  <= S_IDLE;
          end else if (ctrl[C_PARK]) begin
            st         <= S_HOLD;
            resume_mid <= 1'b0;
          end else if (dw[W_NEXT] == '0) begin
            st <= S_IDLE;
          end else begin
            st       <= S_FETCH;
            widx     <= '0;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= dw[W_NEXT][AW-1:0];
          end
        end
        S_HOLD: begin
          if (start) st <= resume_mid ? S_RD : S_LAUNCH;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_IDLE:   status = STAT_IDLE;
      S_LAUNCH: status = STAT_START;
      S_HOLD:   status = STAT_PARK;
      default:  status = STAT_RUN;
    endcase
  end

  // requests wait unchanged for their grant
  assert_req_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // the start-accepted code lasts a single cycle
  assert_launch_once_R11: assert property (@(posedge clk) disable iff (rst)
    (status == STAT_START) |=> (status != STAT_START));

  // parked engine makes no memory traffic
  assert_hold_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    (status == STAT_PARK) |-> !mem_req);

  // end-of-node interrupt is a pulse
  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    eon_irq |=> !eon_irq);

  // an error always lands in idle
  assert_err_idle_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> (status == STAT_IDLE));

  // a paced data read starts only after its line was high
  assert_paced_read_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_req) && !mem_we && (st == S_RD) && (ctrl[REQ_SEL_W-1:0] != '0))
      |-> $past(req_lines[ctrl[REQ_SEL_W-1:0]]));
endmodule

// File: tb/tb_lldma_engine.sv
module tb_lldma_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        pause_req = 1'b0;
  logic [31:0] head_ptr = '0;
  logic [31:0] req_lines;
  logic        mem_req, mem_we, mem_gnt, mem_rvalid, eon_irq, err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  status;

  always #5 clk = ~clk;

  lldma_engine dut (
    .clk(clk), .rst(rst), .start(start), .pause_req(pause_req),
    .head_ptr(head_ptr), .req_lines(req_lines),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .eon_irq(eon_irq), .err(err), .status(status)
  );

  // memory model with a preload port
  logic [31:0] mem [256];
  logic        pl_en = 1'b0;
  logic [31:0] pl_addr = '0, pl_data = '0;
  logic [7:0]  gcnt = '0;
  int          wcount = 0, irq_cnt = 0;
  logic        stall = 1'b0, pace_tog = 1'b1;
  logic [31:0] req_base = '0;

  assign mem_gnt   = stall ? (gcnt[1:0] == 2'b11) : 1'b1;
  assign req_lines = req_base | ((pace_tog && gcnt[0]) ? 32'hFFFF_FFFE : 32'h0);

  always_ff @(posedge clk) begin
    mem_rvalid <= 1'b0;
    gcnt       <= gcnt + 8'd1;
    if (eon_irq) irq_cnt <= irq_cnt + 1;
    if (pl_en) mem[pl_addr[9:2]] <= pl_data;
    else if (mem_req && mem_gnt) begin
      if (mem_we) begin
        mem[mem_addr[9:2]] <= mem_wdata;
        wcount <= wcount + 1;
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[9:2]];
      end
    end
  end

  int tests = 0, fails = 0;
  logic [31:0] expd [64];

  typedef struct packed {
    logic [31:0] ctrl, nb, ll, ss, ds;
    logic        stl;
  } vec_t;
  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'h140, 32'd16, 32'd0, 32'd0,  32'd0,  1'b0},  // R2 linear
    '{32'h140, 32'd24, 32'd8, 32'd16, 32'd12, 1'b0},  // R4 2D
    '{32'h120, 32'd12, 32'd0, 32'd0,  32'd0,  1'b0},  // R3 fixed source
    '{32'h0C0, 32'd12, 32'd0, 32'd0,  32'd0,  1'b0},  // R3 fixed destination
    '{32'h140, 32'd20, 32'd0, 32'd0,  32'd0,  1'b1},  // R13 stalled grants
    '{32'h143, 32'd16, 32'd0, 32'd0,  32'd0,  1'b0},  // R5 line 3
    '{32'h15F, 32'd8,  32'd4, 32'd8,  32'd8,  1'b1}   // R5 external line, R4
  };

  function automatic logic [31:0] pat(input logic [31:0] a);
    return 32'hA500_0000 | a;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] d);
    pl_en = 1'b1; pl_addr = a; pl_data = d;
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  task automatic init_mem();
    for (int i = 0; i < 256; i++)
      put(32'(i * 4), (i >= 128 && i < 192) ? pat(32'(i * 4)) : 32'h0);
  endtask

  task automatic node(input logic [31:0] at, nxt, c, nb, s, d, ll, ss, ds);
    put(at, nxt); put(at + 4, c); put(at + 8, nb); put(at + 12, s);
    put(at + 16, d); put(at + 20, ll); put(at + 24, ss); put(at + 28, ds);
  endtask

  task automatic kick(input logic [31:0] h);
    head_ptr = h; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(input int maxc);
    for (int i = 0; i < maxc; i++) begin
      if (status == 2'd0) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_park(input int maxc);
    for (int i = 0; i < maxc; i++) begin
      if (status == 2'd3) break;
      @(negedge clk);
    end
  endtask

  // expected destination region 0x300..0x3FF from the addressing rules
  task automatic build_exp(input vec_t v, input logic [31:0] s, input logic [31:0] d);
    for (int w = 0; w < 64; w++) expd[w] = 32'h0;
    for (int k = 0; k < int'(v.nb / 4); k++) begin
      logic [31:0] ln, off, sa, da;
      ln  = (v.ll == 0) ? 32'd0 : (32'(k * 4) / v.ll);
      off = (v.ll == 0) ? 32'(k * 4) : (32'(k * 4) % v.ll);
      sa  = v.ctrl[5] ? s : s + ln * v.ss + off;
      da  = v.ctrl[7] ? d : d + ln * v.ds + off;
      expd[(da - 32'h300) >> 2] = pat(sa);
    end
  endtask

  task automatic cmp_dst(input string req);
    int bad = 0; int first = -1;
    for (int w = 0; w < 64; w++)
      if (mem[192 + w] !== expd[w]) begin bad++; if (first < 0) first = w; end
    if (first < 0) first = 0;
    check(bad == 0, req, mem[192 + first], expd[first]);
  endtask

  initial begin
    #(150000 * 10);
    tests++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int w0, i0;
    vec_t vz;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(status == 2'd0 && !mem_req && !eon_irq && !err, "R11 reset", {status, mem_req, eon_irq, err}, 32'h0);

    // table of single-node transfers (R1 R2 R3 R4 R5 R13)
    for (int v = 0; v < NV; v++) begin
      stall = 1'b0;
      init_mem();
      node(32'h40, 32'h0, VECS[v].ctrl, VECS[v].nb, 32'h200, 32'h300, VECS[v].ll, VECS[v].ss, VECS[v].ds);
      build_exp(VECS[v], 32'h200, 32'h300);
      stall = VECS[v].stl;
      kick(32'h40);
      wait_idle(2000);
      cmp_dst($sformatf("R1 R2 R3 R4 R5 R13 vector %0d", v));
      check(status == 2'd0 && !err, "R6 idle after last node", {status, err}, 32'h0);
    end
    stall = 1'b0;

    // R11 start accepted shows code 1 for one cycle
    init_mem();
    node(32'h40, 32'h0, 32'h140, 32'd4, 32'h200, 32'h300, 0, 0, 0);
    kick(32'h40);
    check(status == 2'd1, "R11 start code", status, 32'd1);
    @(negedge clk);
    check(status == 2'd2, "R11 running code", status, 32'd2);
    wait_idle(500);

    // R6 R9 two-node chain, interrupt only on the first node
    init_mem();
    i0 = irq_cnt;
    node(32'h40, 32'h60, 32'h8000_0140, 32'd8, 32'h200, 32'h300, 0, 0, 0);
    node(32'h60, 32'h0,  32'h0000_0140, 32'd8, 32'h210, 32'h320, 0, 0, 0);
    kick(32'h40);
    wait_idle(2000);
    check(mem[192 + 9] == pat(32'h214) && mem[192 + 1] == pat(32'h204), "R6 chain second node", mem[192 + 9], pat(32'h214));
    check(irq_cnt - i0 == 1, "R9 one interrupt pulse", 32'(irq_cnt - i0), 32'd1);

    // R10 park at end of node, resume with next node
    init_mem();
    node(32'h40, 32'h60, 32'h4000_0140, 32'd4, 32'h200, 32'h300, 0, 0, 0);
    node(32'h60, 32'h0,  32'h0000_0140, 32'd4, 32'h210, 32'h320, 0, 0, 0);
    kick(32'h40);
    wait_park(500);
    repeat (20) @(negedge clk);
    check(status == 2'd3 && mem[200] == 32'h0, "R10 parked before next node", {status, mem[200][29:0]}, 32'hC000_0000);
    kick(32'h0);
    wait_idle(1000);
    check(mem[200] == pat(32'h210), "R10 next node after start", mem[200], pat(32'h210));

    // R12 pause input mid-node
    init_mem();
    node(32'h40, 32'h0, 32'h140, 32'd32, 32'h200, 32'h300, 0, 0, 0);
    vz = '{32'h140, 32'd32, 32'd0, 32'd0, 32'd0, 1'b0};
    build_exp(vz, 32'h200, 32'h300);
    kick(32'h40);
    repeat (22) @(negedge clk);
    pause_req = 1'b1;
    wait_park(200);
    w0 = wcount;
    repeat (10) @(negedge clk);
    check(status == 2'd3 && wcount == w0, "R12 paused holds", 32'(wcount - w0), 32'h0);
    pause_req = 1'b0;
    kick(32'h0);
    wait_idle(1000);
    cmp_dst("R12 resume completes node");

    // R5 request line held low stalls the node
    init_mem();
    pace_tog = 1'b0; req_base = 32'h0;
    node(32'h40, 32'h0, 32'h145, 32'd8, 32'h200, 32'h300, 0, 0, 0);
    w0 = wcount;
    kick(32'h40);
    repeat (30) @(negedge clk);
    check(status == 2'd2 && wcount == w0, "R5 line low no writes", 32'(wcount - w0), 32'h0);
    req_base = 32'h20;
    wait_idle(1000);
    check(mem[193] == pat(32'h204), "R5 line high completes", mem[193], pat(32'h204));
    pace_tog = 1'b1; req_base = 32'h0;

    // R13 zero-length node moves nothing
    init_mem();
    node(32'h40, 32'h0, 32'h140, 32'd0, 32'h200, 32'h300, 0, 0, 0);
    w0 = wcount;
    kick(32'h40);
    wait_idle(500);
    check(wcount == w0 && !err && status == 2'd0, "R13 zero count", 32'(wcount - w0), 32'h0);

    // R7 misaligned next pointer
    init_mem();
    node(32'h40, 32'h64, 32'h140, 32'd4, 32'h200, 32'h300, 0, 0, 0);
    kick(32'h40);
    wait_idle(500);
    check(err && status == 2'd0, "R7 misaligned link", {status, err}, 32'h1);

    // R7 misaligned head, err cleared by a new start first
    kick(32'h48);
    wait_idle(50);
    check(err && status == 2'd0, "R7 misaligned head", {status, err}, 32'h1);

    // R8 bad addressing field moves nothing
    init_mem();
    node(32'h40, 32'h0, 32'h100, 32'd8, 32'h200, 32'h300, 0, 0, 0);
    w0 = wcount;
    kick(32'h40);
    wait_idle(500);
    check(err && wcount == w0 && mem[192] == 32'h0, "R8 source field 00", 32'(wcount - w0), 32'h0);
    init_mem();
    node(32'h40, 32'h0, 32'h1C0, 32'd8, 32'h200, 32'h300, 0, 0, 0);
    kick(32'h40);
    wait_idle(500);
    check(err && mem[192] == 32'h0, "R8 destination field 11", mem[192], 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule